// File: doc/BRIEF.md
# Memory-Mapped System Address Decoder

This block stands between the data port of a 32-bit processor and everything that port can reach. Each access carries a byte address. The block sorts it into one of three windows: a read-only instruction memory, a read-write data memory, or a small bank of peripheral registers. It steers write data and the write enable to the data memory. It returns the matching read data in the same cycle, so the memories attached to it must have combinational read.

The peripheral bank keeps a few registers of its own:
- an eight-bit indicator latch, whose output word also shows a divided clock and seven program-counter bits;
- a 32-bit display value;
- a free-running cycle counter.

It also reads switch and button inputs. It presents the handshake and data of a byte-wide serial link. The serial engine and the display drivers sit outside the block and connect through plain valid/ready and data pins. Reading the received byte sends a one-cycle acknowledge to the receiver. Writing a byte to send raises a one-cycle strobe.

Top module: `sys_addr_decoder`

## Requirements
- R1: Byte addresses 0x00400000 to 0x004001FF select the instruction memory. `rom_word_addr` equals address bits [8:2] and a read returns `rom_rdata`. A write there changes no memory and no register.
- R2: Byte addresses 0x10010000 to 0x100101FF select the data memory. `ram_word_addr` equals address bits [8:2] and `ram_wdata` equals `cpu_wdata`. `ram_we` is high exactly while `cpu_we` is high in this window, and a read returns `ram_rdata`.
- R3: Address bits [1:0] never affect decoding, routing or read data.
- R4: The peripheral bank is at base 0xFFFF0000. Offset 0x00 reads the receive-valid flag in bit 0 and offset 0x08 reads the transmit-ready flag in bit 0. Offset 0x04 reads the received byte in bits [7:0]. All other bits of these reads are zero.
- R5: A read of offset 0x04 raises `rx_ack` for one cycle, starting on the clock edge that ends the read. Reads of other offsets leave `rx_ack` low.
- R6: A write to offset 0x0C stores `cpu_wdata[7:0]` on `tx_data` and raises `tx_strobe` for one cycle, both starting on the clock edge that ends the write. `tx_data` changes at no other time.
- R7: A write to offset 0x60 latches `cpu_wdata[7:0]` into `led_out[7:0]` at the ending edge. `led_out[8]` follows `div_clk_in` and `led_out[15:9]` follow `pc_in[8:2]` directly.
- R8: Offset 0x64 reads `dip_in` in bits [15:0]. Offset 0x68 reads `btn_in` in bits [2:0], ordered left, center, right from bit 2 down. Higher bits read zero.
- R9: A write to offset 0x80 stores all 32 bits of `cpu_wdata` on `seg_value` at the ending edge.
- R10: Offset 0xA0 reads a counter. It is zero while reset is held and is incremented at every clock edge after reset is released, so it reads N after N edges.
- R11: Reads return zero from unmapped addresses and from the write-only offsets 0x0C, 0x60 and 0x80. Writes to read-only offsets or unmapped addresses change no output.
- R12: While `rst` is high and after it, `led_out[7:0]`, `seg_value`, `tx_data`, `tx_strobe` and `rx_ack` are zero until written or triggered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Write data |
| cpu_we | input | 1 | Write enable |
| cpu_re | input | 1 | Read enable |
| cpu_rdata | output | 32 | Read data, same cycle |
| rom_word_addr | output | 7 | Instruction memory word index |
| rom_rdata | input | 32 | Instruction memory read data |
| ram_word_addr | output | 7 | Data memory word index |
| ram_we | output | 1 | Data memory write enable |
| ram_wdata | output | 32 | Data memory write data |
| ram_rdata | input | 32 | Data memory read data |
| rx_valid | input | 1 | Receiver holds a byte |
| rx_data | input | 8 | Received byte |
| rx_ack | output | 1 | One-cycle pulse after the received byte is read |
| tx_ready | input | 1 | Transmitter can accept a byte |
| tx_data | output | 8 | Byte to transmit |
| tx_strobe | output | 1 | One-cycle pulse with a new byte |
| pc_in | input | 32 | Program counter, mirrored in part |
| div_clk_in | input | 1 | Divided clock for display |
| led_out | output | 16 | Indicator outputs |
| dip_in | input | 16 | Switch inputs |
| btn_in | input | 3 | Button inputs |
| seg_value | output | 32 | Value for the hex display |

## Verification
Read data depends on the inputs alone. The bench sets address and enable just after a falling edge and samples `cpu_rdata` one nanosecond later, before the next rising edge. The stored outputs (`led_out[7:0]`, `seg_value`, `tx_data`) and the pulses (`tx_strobe`, `rx_ack`) change on the single rising edge that ends the access. Each task therefore holds the access across exactly one rising edge and checks these outputs at the next falling edge. It checks at the falling edge after that to confirm that each pulse has dropped. The counter is checked by counting rising edges from the release of reset and comparing the count in the cycle of the read.

// File: rtl/sysmap_pkg.sv
package sysmap_pkg;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_ROM  = 2'd1,
    TGT_RAM  = 2'd2,
    TGT_MMIO = 2'd3
  } tgt_e;

  // peripheral bank span in address bits
  localparam int MMIO_SPAN_BITS = 8;

  // byte offsets within the peripheral bank
  localparam logic [7:0] OFS_RX_VLD = 8'h00;
  localparam logic [7:0] OFS_RX_BYTE = 8'h04;
  localparam logic [7:0] OFS_TX_RDY = 8'h08;
  localparam logic [7:0] OFS_TX_BYTE = 8'h0C;
  localparam logic [7:0] OFS_IND = 8'h60;
  localparam logic [7:0] OFS_SWITCH = 8'h64;
  localparam logic [7:0] OFS_BUTTON = 8'h68;
  localparam logic [7:0] OFS_HEXDISP = 8'h80;
  localparam logic [7:0] OFS_TICKS = 8'hA0;

  // true when addr lies in the aligned window of 2**span bytes at base
  function automatic logic in_window(input logic [31:0] addr,
                                     input logic [31:0] base,
                                     input int unsigned span);
    return (addr >> span) == (base >> span);
  endfunction

endpackage

// File: rtl/addr_region_decode.sv
module addr_region_decode
  import sysmap_pkg::*;
#(
  parameter logic [31:0] ROM_BASE      = 32'h0040_0000,
  parameter logic [31:0] RAM_BASE      = 32'h1001_0000,
  parameter logic [31:0] MMIO_BASE     = 32'hFFFF_0000,
  parameter int          ROM_BYTE_BITS = 9,
  parameter int          RAM_BYTE_BITS = 9
) (
  input  logic [29:0] word_addr,
  output tgt_e        tgt,
  output logic [7:0]  mmio_ofs
);
  logic [31:0] byte_addr;

  always_comb begin
    byte_addr = {word_addr, 2'b00};
    if (in_window(byte_addr, ROM_BASE, ROM_BYTE_BITS))
      tgt = TGT_ROM;
    else if (in_window(byte_addr, RAM_BASE, RAM_BYTE_BITS))
      tgt = TGT_RAM;
    else if (in_window(byte_addr, MMIO_BASE, MMIO_SPAN_BITS))
      tgt = TGT_MMIO;
    else
      tgt = TGT_NONE;
    mmio_ofs = byte_addr[7:0];
  end
endmodule

// File: rtl/periph_regs.sv
module periph_regs
  import sysmap_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       ofs,
  input  logic [31:0]      wdata,
  output logic [7:0]       led_lo,
  output logic [31:0]      seg_value,
  output logic [7:0]       tx_data,
  output logic             tx_strobe,
  output logic             rx_ack,
  output logic [CNT_W-1:0] cycle_cnt
);
  // named internal events, shared with the assertions
  logic wr_tx, wr_led, wr_seg, rd_rx;

  always_comb begin
    wr_tx  = wr_en && (ofs == OFS_TX_BYTE);
    wr_led = wr_en && (ofs == OFS_IND);
    wr_seg = wr_en && (ofs == OFS_HEXDISP);
    rd_rx  = rd_en && (ofs == OFS_RX_BYTE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      led_lo    <= '0;
      seg_value <= '0;
      tx_data   <= '0;
      tx_strobe <= 1'b0;
      rx_ack    <= 1'b0;
      cycle_cnt <= '0;
    end else begin
      tx_strobe <= wr_tx;
      rx_ack    <= rd_rx;
      cycle_cnt <= cycle_cnt + 1'b1;
      if (wr_tx)  tx_data   <= wdata[7:0];
      if (wr_led) led_lo    <= wdata[7:0];
      if (wr_seg) seg_value <= wdata;
    end
  end

  // R6: tx byte only moves together with its strobe
  p_tx_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !tx_strobe |-> $stable(tx_data));
  // R6: strobe lasts one cycle unless another send follows
  p_tx_single_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_strobe && !wr_tx) |=> !tx_strobe);
  // R5: ack lasts one cycle unless another read follows
  p_rx_single_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_ack && !rd_rx) |=> !rx_ack);
  // R7: indicator latch holds when not written
  p_led_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_led |=> $stable(led_lo));
  // R9: display value holds when not written
  p_seg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_seg |=> $stable(seg_value));
  // R10: counter steps by one every cycle out of reset
  p_cnt_step_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cycle_cnt == CNT_W'($past(cycle_cnt) + 1'b1));
endmodule

// File: rtl/rdata_mux.sv
module rdata_mux
  import sysmap_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  tgt_e             tgt,
  input  logic [7:0]       ofs,
  input  logic [31:0]      rom_rdata,
  input  logic [31:0]      ram_rdata,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             tx_ready,
  input  logic [15:0]      dip_in,
  input  logic [2:0]       btn_in,
  input  logic [CNT_W-1:0] cycle_cnt,
  output logic [31:0]      rdata
);
  // peripheral read value; write-only and unlisted offsets give zero
  function automatic logic [31:0] mmio_read(input logic [7:0] o);
    case (o)
      OFS_RX_VLD:  return {31'd0, rx_valid};
      OFS_RX_BYTE: return {24'd0, rx_data};
      OFS_TX_RDY:  return {31'd0, tx_ready};
      OFS_SWITCH:  return {16'd0, dip_in};
      OFS_BUTTON:  return {29'd0, btn_in};
      OFS_TICKS:   return 32'(cycle_cnt);
      default:     return 32'd0;
    endcase
  endfunction

  always_comb begin
    unique case (tgt)
      TGT_ROM:  rdata = rom_rdata;
      TGT_RAM:  rdata = ram_rdata;
      TGT_MMIO: rdata = mmio_read(ofs);
      default:  rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/sys_addr_decoder.sv
module sys_addr_decoder
  import sysmap_pkg::*;
#(
  parameter logic [31:0] ROM_BASE      = 32'h0040_0000,
  parameter logic [31:0] RAM_BASE      = 32'h1001_0000,
  parameter logic [31:0] MMIO_BASE     = 32'hFFFF_0000,
  parameter int          ROM_BYTE_BITS = 9,
  parameter int          RAM_BYTE_BITS = 9,
  parameter int          CNT_W         = 32,
  localparam int         ROM_AW        = ROM_BYTE_BITS - 2,
  localparam int         RAM_AW        = RAM_BYTE_BITS - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       cpu_addr,
  input  logic [31:0]       cpu_wdata,
  input  logic              cpu_we,
  input  logic              cpu_re,
  output logic [31:0]       cpu_rdata,
  output logic [ROM_AW-1:0] rom_word_addr,
  input  logic [31:0]       rom_rdata,
  output logic [RAM_AW-1:0] ram_word_addr,
  output logic              ram_we,
  output logic [31:0]       ram_wdata,
  input  logic [31:0]       ram_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ack,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_strobe,
  input  logic [31:0]       pc_in,
  input  logic              div_clk_in,
  output logic [15:0]       led_out,
  input  logic [15:0]       dip_in,
  input  logic [2:0]        btn_in,
  output logic [31:0]       seg_value
);
  tgt_e             tgt;
  logic [7:0]       mmio_ofs;
  logic [7:0]       led_lo;
  logic [CNT_W-1:0] cycle_cnt;
  logic             mmio_wr, mmio_rd;
  logic             unused_bits;

  // R3: byte lane bits are dropped before decoding
  assign unused_bits = ^{cpu_addr[1:0], pc_in[31:9], pc_in[1:0]};

  addr_region_decode #(
    .ROM_BASE(ROM_BASE), .RAM_BASE(RAM_BASE), .MMIO_BASE(MMIO_BASE),
    .ROM_BYTE_BITS(ROM_BYTE_BITS), .RAM_BYTE_BITS(RAM_BYTE_BITS)
  ) u_dec (
    .word_addr(cpu_addr[31:2]),
    .tgt      (tgt),
    .mmio_ofs (mmio_ofs)
  );

  assign rom_word_addr = cpu_addr[ROM_BYTE_BITS-1:2];
  assign ram_word_addr = cpu_addr[RAM_BYTE_BITS-1:2];
  assign ram_wdata     = cpu_wdata;
  assign ram_we        = cpu_we && (tgt == TGT_RAM);
  assign mmio_wr       = cpu_we && (tgt == TGT_MMIO);
  assign mmio_rd       = cpu_re && (tgt == TGT_MMIO);

  periph_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (mmio_wr),
    .rd_en    (mmio_rd),
    .ofs      (mmio_ofs),
    .wdata    (cpu_wdata),
    .led_lo   (led_lo),
    .seg_value(seg_value),
    .tx_data  (tx_data),
    .tx_strobe(tx_strobe),
    .rx_ack   (rx_ack),
    .cycle_cnt(cycle_cnt)
  );

  assign led_out = {pc_in[8:2], div_clk_in, led_lo};

  rdata_mux #(.CNT_W(CNT_W)) u_mux (
    .tgt      (tgt),
    .ofs      (mmio_ofs),
    .rom_rdata(rom_rdata),
    .ram_rdata(ram_rdata),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .tx_ready (tx_ready),
    .dip_in   (dip_in),
    .btn_in   (btn_in),
    .cycle_cnt(cycle_cnt),
    .rdata    (cpu_rdata)
  );

  // R2: memory writes only land inside the data window
  p_ram_we_window_r2: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (cpu_addr[31:RAM_BYTE_BITS] == RAM_BASE[31:RAM_BYTE_BITS]));
  // R1: an instruction-window write never reaches the data memory
  p_rom_readonly_r1: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[31:ROM_BYTE_BITS] == ROM_BASE[31:ROM_BYTE_BITS]) |-> !ram_we);
  // R11: unmapped addresses read zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (tgt == TGT_NONE) |-> (cpu_rdata == 32'd0));
  // R5: no acknowledge without a preceding peripheral read
  p_ack_cause_r5: assert property (@(posedge clk) disable iff (rst)
    rx_ack |-> $past(mmio_rd));
endmodule

// File: tb/tb_sys_addr_decoder.sv
`timescale 1ns/1ps
module tb_sys_addr_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0, cpu_rdata;
  logic        cpu_we = 1'b0, cpu_re = 1'b0;
  logic [6:0]  rom_word_addr, ram_word_addr;
  logic [31:0] rom_rdata, ram_rdata, ram_wdata;
  logic        ram_we;
  logic        rx_valid = 1'b0, tx_ready = 1'b0;
  logic [7:0]  rx_data = '0, tx_data;
  logic        rx_ack, tx_strobe;
  logic [31:0] pc_in = '0;
  logic        div_clk_in = 1'b0;
  logic [15:0] led_out, dip_in = '0;
  logic [2:0]  btn_in = '0;
  logic [31:0] seg_value;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] mem [0:127];
  logic [31:0] v;

  always #2.5 clk = ~clk;

  sys_addr_decoder dut (.*);

  assign rom_rdata = 32'h0D00_0000 | {25'd0, rom_word_addr};
  assign ram_rdata = mem[ram_word_addr];
  always @(posedge clk) if (ram_we) mem[ram_word_addr] <= ram_wdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // read: drive after a falling edge, sample before the rising edge
  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    cpu_addr = a; cpu_re = 1'b1; cpu_we = 1'b0;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_re = 1'b0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1; cpu_re = 1'b0;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 led low", {24'd0, led_out[7:0]}, 32'd0);
    chk("R12 seg", seg_value, 32'd0);
    chk("R12 tx_data", {24'd0, tx_data}, 32'd0);
    chk("R12 pulses", {30'd0, tx_strobe, rx_ack}, 32'd0);
  endtask

  task automatic t_rom();
    rd(32'h0040_0000, v); chk("R1 rom first", v, 32'h0D00_0000);
    rd(32'h0040_01FC, v); chk("R1 rom last", v, 32'h0D00_007F);
    wr(32'h0040_0014, 32'hDEAD_BEEF);
    rd(32'h1001_0014, v); chk("R1 rom write ignored", v, 32'hA500_0005);
  endtask

  task automatic t_ram();
    rd(32'h1001_01FC, v); chk("R2 ram preload", v, 32'hA500_007F);
    cpu_addr = 32'h1001_0020; cpu_wdata = 32'h1234_5678; cpu_we = 1'b1;
    #1 chk("R2 ram_we", {31'd0, ram_we}, 32'd1);
    @(negedge clk); cpu_we = 1'b0;
    rd(32'h1001_0020, v); chk("R2 ram readback", v, 32'h1234_5678);
    rd(32'h1001_0200, v); chk("R11 past ram end", v, 32'd0);
  endtask

  task automatic t_lowbits();
    rd(32'h1001_0007, v); chk("R3 ram low bits", v, 32'hA500_0001);
    rd(32'h0040_000A, v); chk("R3 rom low bits", v, 32'h0D00_0002);
    wr(32'hFFFF_0083, 32'hCAFE_F00D);
    chk("R3 seg low bits", seg_value, 32'hCAFE_F00D);
  endtask

  task automatic t_uart_status();
    rx_valid = 1'b1; tx_ready = 1'b0; rx_data = 8'h9C;
    rd(32'hFFFF_0000, v); chk("R4 rx valid set", v, 32'd1);
    rd(32'hFFFF_0008, v); chk("R4 tx ready clear", v, 32'd0);
    rx_valid = 1'b0; tx_ready = 1'b1;
    rd(32'hFFFF_0000, v); chk("R4 rx valid clear", v, 32'd0);
    rd(32'hFFFF_0008, v); chk("R4 tx ready set", v, 32'd1);
    chk("R5 no ack from status read", {31'd0, rx_ack}, 32'd0);
  endtask

  task automatic t_rx_ack();
    rx_data = 8'hE7;
    rd(32'hFFFF_0004, v); chk("R4 rx byte", v, 32'h0000_00E7);
    chk("R5 ack pulse", {31'd0, rx_ack}, 32'd1);
    @(negedge clk);
    chk("R5 ack drops", {31'd0, rx_ack}, 32'd0);
  endtask

  task automatic t_tx();
    chk("R6 strobe idle", {31'd0, tx_strobe}, 32'd0);
    wr(32'hFFFF_000C, 32'h1111_2242);
    chk("R6 tx byte", {24'd0, tx_data}, 32'h42);
    chk("R6 strobe pulse", {31'd0, tx_strobe}, 32'd1);
    @(negedge clk);
    chk("R6 strobe drops", {31'd0, tx_strobe}, 32'd0);
    chk("R6 tx byte held", {24'd0, tx_data}, 32'h42);
    rd(32'hFFFF_000C, v); chk("R11 tx reads zero", v, 32'd0);
  endtask

  task automatic t_led();
    pc_in = 32'h0040_0154; div_clk_in = 1'b1;
    wr(32'hFFFF_0060, 32'hFFFF_FF3C);
    chk("R7 led word", {16'd0, led_out}, {16'd0, 7'h55, 1'b1, 8'h3C});
    pc_in = 32'h0040_0008; div_clk_in = 1'b0;
    #1 chk("R7 led mirror", {16'd0, led_out}, {16'd0, 7'h02, 1'b0, 8'h3C});
    rd(32'hFFFF_0060, v); chk("R11 led reads zero", v, 32'd0);
  endtask

  task automatic t_switches();
    dip_in = 16'hBEEF; btn_in = 3'b101;
    rd(32'hFFFF_0064, v); chk("R8 dip", v, 32'h0000_BEEF);
    rd(32'hFFFF_0068, v); chk("R8 buttons", v, 32'h0000_0005);
    btn_in = 3'b010;
    rd(32'hFFFF_0068, v); chk("R8 center button", v, 32'h0000_0002);
  endtask

  task automatic t_seg();
    wr(32'hFFFF_0080, 32'h0123_4567);
    chk("R9 seg", seg_value, 32'h0123_4567);
    rd(32'hFFFF_0080, v); chk("R11 seg reads zero", v, 32'd0);
  endtask

  task automatic t_unmapped();
    rd(32'h2000_0000, v); chk("R11 unmapped read", v, 32'd0);
    rd(32'hFFFF_0020, v); chk("R11 unlisted offset", v, 32'd0);
    cpu_addr = 32'h2000_0040; cpu_wdata = 32'h5A5A_5A5A; cpu_we = 1'b1;
    #1 chk("R11 unmapped no ram_we", {31'd0, ram_we}, 32'd0);
    @(negedge clk); cpu_we = 1'b0;
    wr(32'hFFFF_0064, 32'h0000_00AA);
    wr(32'hFFFF_0008, 32'h0000_0077);
    chk("R11 ro write no strobe", {31'd0, tx_strobe}, 32'd0);
    chk("R11 led unchanged", {24'd0, led_out[7:0]}, 32'h3C);
    chk("R11 seg unchanged", seg_value, 32'h0123_4567);
    chk("R11 tx unchanged", {24'd0, tx_data}, 32'h42);
  endtask

  task automatic t_counter();
    @(negedge clk);
    do_reset();
    t_reset();
    repeat (10) @(posedge clk);
    @(negedge clk);
    rd(32'hFFFF_00A0, v); chk("R10 count after 10", v, 32'd10);
    rd(32'hFFFF_00A0, v); chk("R10 count after 11", v, 32'd11);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 32'hA500_0000 | i;
    @(negedge clk);
    do_reset();
    t_reset();
    t_rom();
    t_ram();
    t_lowbits();
    t_uart_status();
    t_rx_ack();
    t_tx();
    t_led();
    t_switches();
    t_seg();
    t_unmapped();
    t_counter();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule